// File: doc/BRIEF.md
# Stack-Top Branch Decision Unit

This unit settles the outcome of a conditional branch in a CPU whose operands live on a register stack. Each cycle the decoder may present one branch. It gives the branch kind, the value of the top-of-stack word A, the current condition-code flags N and Z, and the instruction's indirect-select bit. One clock later the unit reports four things: whether the branch is taken, whether a taken branch goes through an indirect target, whether A must be removed from the stack, and whether the program counter should simply step to the next instruction.

Two families of branch are handled. The stack-testing branches examine A and always consume it, taken or not. The flag-testing branch looks only at N and Z and leaves the stack alone. Forming the target address, fetching an indirect target and writing the program counter are the job of downstream logic.

Branch kind encoding on `br_kind`: 3'd1 = branch when A is nonzero, 3'd2 = branch when A is zero, 3'd3 = branch when equal. Every other value is unrecognised.

Top module: `stack_branch_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset, all outputs (`dec_valid`, `take`, `indirect`, `pop_a`, `seq_next`) are 0.
- R2: For kind 3'd1 the branch is taken exactly when `a_top` is not zero.
- R3: For kind 3'd2 the branch is taken exactly when `a_top` equals zero.
- R4: Kinds 3'd1 and 3'd2 assert `pop_a` whether or not the branch is taken.
- R5: For kind 3'd3 the branch is taken only when `cc_n` = 0 and `cc_z` = 1.
- R6: Kind 3'd3 never asserts `pop_a`.
- R7: For a taken branch, `indirect` equals the `ind_sel` input (1 = indirect target, 0 = direct).
- R8: For a branch that is not taken, `seq_next` is 1 and `indirect` is 0, whatever `ind_sel` is.
- R9: An unrecognised kind (0, 4 to 7) gives not taken, no pop, `seq_next` = 1.
- R10: Results appear exactly one cycle after `br_valid` is high. A cycle without `br_valid` produces all-zero outputs on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_kind | input | 3 | Branch kind code |
| a_top | input | WIDTH | Top-of-stack word A |
| cc_n | input | 1 | Condition-code negative flag |
| cc_z | input | 1 | Condition-code zero flag |
| ind_sel | input | 1 | Instruction indirect-select bit |
| dec_valid | output | 1 | Decision outputs are valid |
| take | output | 1 | Branch taken |
| indirect | output | 1 | Taken branch uses an indirect target |
| pop_a | output | 1 | Remove A from the stack |
| seq_next | output | 1 | Advance the program counter sequentially |

## Verification
On every cycle the assertions compare each presented branch with the decision registered one cycle later. They cover the A-zero and A-nonzero outcomes, the unconditional pop for stack-testing kinds, the missing pop and flag rule for the equal branch, the masking of `indirect` when not taken, and idle cycles. Only the bench's scenarios show that particular words reach the right result: one-hot and all-ones values of A, every N/Z combination, each unrecognised code, and back-to-back branches with no idle gap.

// File: rtl/stack_branch_unit.sv
module stack_branch_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [2:0]       br_kind,
  input  logic [WIDTH-1:0] a_top,
  input  logic             cc_n,
  input  logic             cc_z,
  input  logic             ind_sel,
  output logic             dec_valid,
  output logic             take,
  output logic             indirect,
  output logic             pop_a,
  output logic             seq_next
);

  localparam logic [2:0] K_ANZ = 3'd1;
  localparam logic [2:0] K_AZ  = 3'd2;
  localparam logic [2:0] K_EQ  = 3'd3;

  logic a_is_zero, is_anz, is_az, is_eq, cond, hit;

  assign a_is_zero = (a_top == '0);
  assign is_anz    = (br_kind == K_ANZ);
  assign is_az     = (br_kind == K_AZ);
  assign is_eq     = (br_kind == K_EQ);
  assign cond      = (is_anz & ~a_is_zero) | (is_az & a_is_zero) | (is_eq & ~cc_n & cc_z);
  assign hit       = br_valid & cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      take      <= 1'b0;
      indirect  <= 1'b0;
      pop_a     <= 1'b0;
      seq_next  <= 1'b0;
    end else begin
      dec_valid <= br_valid;
      take      <= hit;
      indirect  <= hit & ind_sel;
      pop_a     <= br_valid & (is_anz | is_az);
      seq_next  <= br_valid & ~cond;
    end
  end

  a_r2_anz_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd1 && a_top != '0) |=> take);
  a_r2_anz_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd1 && a_top == '0) |=> (!take && seq_next));
  a_r3_az_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd2 && a_top == '0) |=> take);
  a_r3_az_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd2 && a_top != '0) |=> (!take && seq_next));
  a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && (br_kind == 3'd1 || br_kind == 3'd2)) |=> pop_a);
  a_r5_eq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd3 && (cc_n || !cc_z)) |=> !take);
  a_r6_eq_nopop: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd3) |=> !pop_a);
  a_r8_ind_masked: assert property (@(posedge clk) disable iff (!rst_n)
    indirect |-> take);
  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones({take, seq_next}) == 1);
  a_r9_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && (br_kind == 3'd0 || br_kind > 3'd3)) |=> (!take && !pop_a && seq_next));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> (!dec_valid && !take && !pop_a && !seq_next && !indirect));

endmodule

// File: tb/sim_stack_branch_unit.sv
module sim_stack_branch_unit;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 1'b0, cc_n = 1'b0, cc_z = 1'b0, ind_sel = 1'b0;
  logic [2:0] br_kind = 3'd0;
  logic [W-1:0] a_top = '0;
  logic dec_valid, take, indirect, pop_a, seq_next;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  stack_branch_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
    .a_top(a_top), .cc_n(cc_n), .cc_z(cc_z), .ind_sel(ind_sel),
    .dec_valid(dec_valid), .take(take), .indirect(indirect),
    .pop_a(pop_a), .seq_next(seq_next));

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got v/t/i/p/s=%b expected %b", req, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] k, logic [W-1:0] a, logic n, logic z, logic ind);
    @(negedge clk);
    br_valid = 1'b1; br_kind = k; a_top = a; cc_n = n; cc_z = z; ind_sel = ind;
    @(posedge clk); #1;
  endtask

  function automatic logic [4:0] outs();
    return {dec_valid, take, indirect, pop_a, seq_next};
  endfunction

  task automatic t_reset();
    chk("R1 in reset", outs(), 5'b00000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", outs(), 5'b00000);
  endtask

  task automatic t_anz();
    issue(3'd1, 16'h0001, 0, 0, 0); chk("R2 R4 anz low bit", outs(), 5'b11010);
    issue(3'd1, 16'h8000, 1, 1, 1); chk("R2 R7 anz indirect", outs(), 5'b11110);
    issue(3'd1, 16'h0000, 0, 1, 1); chk("R2 R4 R8 anz zero", outs(), 5'b10011);
  endtask

  task automatic t_az();
    issue(3'd2, 16'h0000, 1, 0, 0); chk("R3 R4 az zero", outs(), 5'b11010);
    issue(3'd2, 16'h0000, 0, 0, 1); chk("R3 R7 az indirect", outs(), 5'b11110);
    issue(3'd2, 16'hFFFF, 0, 1, 1); chk("R3 R4 R8 az ones", outs(), 5'b10011);
  endtask

  task automatic t_eq();
    for (int c = 0; c < 4; c++) begin
      logic n, z;
      n = c[1]; z = c[0];
      issue(3'd3, 16'h1234, n, z, 1'b1);
      if (!n && z) chk("R5 R6 R7 eq taken", outs(), 5'b11100);
      else         chk("R5 R6 R8 eq fall", outs(), 5'b10001);
    end
    issue(3'd3, 16'h0000, 0, 1, 0); chk("R5 R7 eq direct", outs(), 5'b11000);
  endtask

  task automatic t_unknown();
    for (int k = 0; k < 8; k++) begin
      if (k >= 1 && k <= 3) continue;
      issue(3'(k), 16'h0000, 0, 1, 1);
      chk("R9 unknown kind", outs(), 5'b10001);
    end
  endtask

  task automatic t_idle();
    issue(3'd1, 16'h00F0, 0, 0, 1);
    @(negedge clk); br_valid = 1'b0; br_kind = 3'd2; a_top = '0;
    @(posedge clk); #1;
    chk("R10 idle gap", outs(), 5'b00000);
    issue(3'd2, 16'h0000, 0, 0, 0); chk("R10 after gap", outs(), 5'b11010);
    @(negedge clk); br_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 5000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_anz();
    t_az();
    t_eq();
    t_unknown();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule